// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port controlled through a simple memory-mapped bus. The bus has an address, write data, a write enable and read data. Each pin has a direction bit. A pin whose bit is set drives its output latch onto the pad, with the output enable asserted. A pin whose bit is clear is an input. Its pad level passes through a two-flop synchronizer before software sees it.

The pin data is not held at one address. It is spread across a window of word addresses. Address bit n+2 is a per-pin select for pin n:
- A write to the window changes only the selected pins.
- A read from the window shows only the selected pins.

Software can therefore set or clear a single pin with one store and no read-modify-write. Only output pins take data writes. To drive a pin to a known value, software first sets its direction to output and then writes the value. Read data is combinational from the address presented in the same cycle.

Top module: `gpio_mport`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the port shows all pins as inputs. This means pin_oe = 0, pin_out = 0, and a read of offset 0x400 returns 0.
- R2: Offset 0x400 holds the direction register. A write there loads all 8 bits, and a read there returns them unchanged. Bit n = 1 makes pin n an output. pin_oe[n] follows direction bit n from the cycle after the write.
- R3: A write to an offset in 0x000–0x3FC takes bus_addr[9:2] as a pin mask. Bit n+2 of the address selects pin n. Each selected output pin takes bus_wdata[n] as its new pin_out value on the next clock edge. Every other pin keeps its pin_out value, so offset 0x000 changes nothing and offset 0x3FC reaches every pin.
- R4: A data write has no effect on the output latch of a pin whose direction bit is 0. The pin's pin_out value keeps its old value, including after the pin is later turned into an output.
- R5: A read from the data window returns 0 in every bit whose address mask bit is 0.
- R6: A read from the data window returns the current output latch value for a selected output pin.
- R7: A read from the data window returns the synchronized pad level for a selected input pin. A change on pin_in that is present at clock edge k first appears in the read data after clock edge k+1.
- R8: Any offset that is neither in the data window nor at 0x400 reads as 0. A write to such an offset changes neither pin_out nor pin_oe. Examples are 0x404 and 0x800.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable, sampled on the rising clock edge |
| bus_rdata | output | 8 | Read data for the offset on bus_addr |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_oe | output | 8 | Per-pin output enable (the direction register) |
| pin_out | output | 8 | Per-pin output latch values |

## Verification
Some internal faults show at the ports on the very next edge:
- A wrong direction bit shows at once on pin_oe, and on the read of 0x400.
- A latch updated for a pin that should have been skipped shows on pin_out on the very next edge. The pin may have been skipped because it was unselected, because it is an input, or because the write went to an undecoded offset.

A synchronizer stage that is missing, stuck or extra does not show on pin_oe or pin_out. It shows only in window reads of input pins, as a level that arrives one cycle early or late, or never arrives. The bench therefore reads input pins on consecutive cycles after a pad change. A mask decode that is off by one position shows in the read data in the same cycle as the access.

// File: rtl/gpio_mport_pkg.sv
package gpio_mport_pkg;

    localparam int PORT_PINS   = 8;
    localparam int PORT_ADDR_W = 12;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

    // New latch value: selected output pins take the write data, all others hold.
    function automatic logic [PORT_PINS-1:0] merge_pins(
        input logic [PORT_PINS-1:0] cur,
        input logic [PORT_PINS-1:0] wdata,
        input logic [PORT_PINS-1:0] take
    );
        return (cur & ~take) | (wdata & take);
    endfunction

endpackage

// File: rtl/gpio_mport_decode.sv
module gpio_mport_decode
    import gpio_mport_pkg::*;
#(
    parameter int NPINS      = PORT_PINS,
    parameter int ADDR_W     = PORT_ADDR_W,
    parameter int DIR_OFFSET = 'h400
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [NPINS-1:0]  mask
);
    localparam int WIN_TOP = NPINS + 2;
    localparam logic [ADDR_W-3:0] DIR_WORD = ADDR_W'(DIR_OFFSET) >> 2;

    logic in_window;
    logic is_dir;
    logic [1:0] unused_byte_lane;

    assign unused_byte_lane = addr[1:0];
    assign in_window = (addr[ADDR_W-1:WIN_TOP] == '0);
    assign is_dir    = (addr[ADDR_W-1:2] == DIR_WORD);
    assign mask      = in_window ? addr[WIN_TOP-1:2] : '0;

    always_comb begin
        if (in_window)   sel = SEL_DATA;
        else if (is_dir) sel = SEL_DIR;
        else             sel = SEL_NONE;
    end
endmodule

// File: rtl/gpio_mport_sync.sv
module gpio_mport_sync
    import gpio_mport_pkg::*;
#(
    parameter int NPINS = PORT_PINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);
    logic [NPINS-1:0] stage [SYNC_STAGES];

    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[SYNC_STAGES-1];

    // The window below counts cycles since reset, so the latency check starts
    // only once the chain holds real samples.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    assert_sync_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_mport_regs.sv
module gpio_mport_regs
    import gpio_mport_pkg::*;
#(
    parameter int NPINS = PORT_PINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  reg_sel_e         sel,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] lat_q
);
    logic [NPINS-1:0] take;
    logic data_wr;
    logic dir_wr;

    assign data_wr = we && (sel == SEL_DATA);
    assign dir_wr  = we && (sel == SEL_DIR);
    assign take    = data_wr ? (mask & dir_q) : '0;

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (dir_wr) dir_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= merge_pins(lat_q, wdata, take);
    end

    assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
        dir_wr |=> (dir_q == $past(wdata)));

    assert_selected_take_R3: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (((lat_q ^ $past(wdata)) & $past(mask & dir_q)) == '0));

    assert_unselected_hold_R3: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (((lat_q ^ $past(lat_q)) & ~$past(mask)) == '0));

    assert_input_hold_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((lat_q ^ $past(lat_q)) & ~$past(dir_q)) == '0));
endmodule

// File: rtl/gpio_mport.sv
module gpio_mport
    import gpio_mport_pkg::*;
#(
    parameter int NPINS      = PORT_PINS,
    parameter int ADDR_W     = PORT_ADDR_W,
    parameter int DIR_OFFSET = 'h400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_out
);
    reg_sel_e         sel;
    logic [NPINS-1:0] mask;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] lat_q;
    logic [NPINS-1:0] pad_sync;
    logic [NPINS-1:0] win_rd;

    gpio_mport_decode #(
        .NPINS(NPINS), .ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFFSET)
    ) u_decode (
        .addr(bus_addr), .sel(sel), .mask(mask)
    );

    gpio_mport_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pad_sync)
    );

    gpio_mport_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .mask(mask),
        .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q)
    );

    genvar p;
    generate
        for (p = 0; p < NPINS; p++) begin : g_rd
            assign win_rd[p] = mask[p] & (dir_q[p] ? lat_q[p] : pad_sync[p]);
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_DATA: bus_rdata = win_rd;
            SEL_DIR:  bus_rdata = dir_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_oe  = dir_q;
    assign pin_out = lat_q;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0));

    assert_undecoded_read_R8: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (bus_rdata == '0));

    assert_undecoded_write_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_NONE) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_unselected_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_DATA) |-> ((bus_rdata & ~mask) == '0));

    assert_output_read_R6: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_DATA) |-> ((bus_rdata & mask & pin_oe) == (pin_out & mask & pin_oe)));
endmodule

// File: tb/gpio_mport_bench.sv
module gpio_mport_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_oe;
    logic [7:0]  pin_out;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    int m_dir = 0, m_lat = 0, m_s1 = 0, m_s2 = 0;

    always #10 clk = ~clk;

    gpio_mport u_gpio_mport (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    function automatic int expect_read(int a);
        int msk, v;
        if (a < 'h400) begin
            msk = (a >> 2) & 'hFF;
            v = 0;
            for (int n = 0; n < 8; n++)
                if ((msk >> n) & 1)
                    v |= (((m_dir >> n) & 1) ? ((m_lat >> n) & 1) : ((m_s2 >> n) & 1)) << n;
            return v;
        end
        if ((a >> 2) == 'h100) return m_dir;
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_dir = 0; m_lat = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            m_s2 = m_s1;
            m_s1 = int'(pin_in);
            if (bus_we) begin
                if (int'(bus_addr) < 'h400) begin
                    int take;
                    take = ((int'(bus_addr) >> 2) & 'hFF) & m_dir;
                    m_lat = (m_lat & ~take) | (int'(bus_wdata) & take);
                end else if ((int'(bus_addr) >> 2) == 'h100) begin
                    m_dir = int'(bus_wdata);
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #5;
        if (!rst) begin
            check("R2", int'(pin_oe), m_dir);
            check("R3", int'(pin_out), m_lat);
            check(int'(bus_addr) < 'h400 ? "R5" : "R8", int'(bus_rdata), expect_read(int'(bus_addr)));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = 12'(a); bus_wdata = 8'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #6;
    endtask

    task automatic rd(int a, string req, int exp);
        @(negedge clk);
        bus_addr = 12'(a); bus_we = 1'b0;
        #6;
        check(req, int'(bus_rdata), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #6;
        check("R1", int'(pin_oe), 0);
        check("R1", int'(pin_out), 0);
        @(negedge clk);
        rst = 1'b0;
        bus_addr = 12'h400;
        #6;
        check("R1", int'(bus_rdata), 0);
        check("R1", int'(pin_oe), 0);

        wr('h3FC, 'hFF);
        check("R4", int'(pin_out), 0);

        wr('h400, 'h0F);
        check("R2", int'(pin_oe), 'h0F);
        rd('h400, "R2", 'h0F);

        wr('h3FC, 'hA5);
        check("R4", int'(pin_out), 'h05);
        wr('h010, 'h00);
        check("R3", int'(pin_out), 'h01);
        wr('h020, 'hFF);
        check("R3", int'(pin_out), 'h09);
        wr('h000, 'hFF);
        check("R3", int'(pin_out), 'h09);

        @(negedge clk);
        pin_in = 8'hC0;
        repeat (3) @(negedge clk);
        rd('h3FC, "R6", 'hC9);
        rd('h03C, "R5", 'h09);
        rd('h300, "R7", 'hC0);

        // latency: pad change before edge k visible after edge k+1
        @(negedge clk);
        pin_in = 8'h30; bus_addr = 12'h0C0;
        #6;
        check("R7", int'(bus_rdata), 'h00);
        @(negedge clk); #6;
        check("R7", int'(bus_rdata), 'h00);
        @(negedge clk); #6;
        check("R7", int'(bus_rdata), 'h30);

        wr('h404, 'hFF);
        check("R8", int'(pin_oe), 'h0F);
        wr('h800, 'hFF);
        check("R8", int'(pin_out), 'h09);
        rd('h404, "R8", 0);
        rd('h800, "R8", 0);

        wr('h400, 'hFF);
        check("R4", int'(pin_out), 'h09);
        wr('h3FC, 'h3C);
        check("R3", int'(pin_out), 'h3C);
        rd('h3FC, "R6", 'h3C);
        rd('h400, "R2", 'hFF);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule